// File: doc/BRIEF.md
# PCI Address Translation Window Unit

This block keeps two small sets of address translation windows for a PCI host bridge. The outbound set maps processor addresses onto the PCI bus. The inbound set maps PCI bus master addresses onto local memory. Software programs the windows through a 32-bit register port that decodes a 1 KB offset space.

Each window holds four registers: a translated target page, an extension word, a base page and an attribute word. The attribute word carries an enable flag and a size code. Base and target registers count 4 KB pages, not bytes.

Two combinational lookup ports each take a 44-bit address. Each returns a hit flag and the translated address. The lowest-numbered enabled window that contains the address supplies the translation. A free-standing 32-bit scratch timer register shares the register space.

Top module: `pciwin_unit`

## Requirements
- R1: After a synchronous active-high reset, every register reads as zero and neither lookup port reports a hit.
- R2: The outbound windows 0..3 use the 32-byte groups at offsets 0x020, 0x040, 0x060 and 0x080. Window index = (offset >> 5) - 1. Inside a group: 0x00 target page, 0x04 extension, 0x08 base page, 0x10 attributes.
- R3: The inbound windows 0..2 use the groups at 0x1A0, 0x1C0 and 0x1E0. Window index = ((offset >> 5) & 3) - 1. Inside a group: 0x00 target page, 0x08 base page, 0x0C extension, 0x10 attributes.
- R4: Any offset whose group is 0x220 (0x220..0x23F) reads and writes one 32-bit timer register, which only stores its value.
- R5: A read at any other offset, including an unlisted offset inside a window group, returns zero. A write there changes no register.
- R6: A window whose attribute bit 31 is clear never produces a hit.
- R7: An enabled window covers the byte range [base, base + (2 << attr[5:0])), where base is the base register shifted left by 12. Hits occur exactly inside that range. Ranges that reach past 2^44 cover everything from base upwards.
- R8: On a hit, the output is (target << 12) + (address - base), modulo 2^44. On a miss, the output is zero.
- R9: When several enabled windows of one set contain the address, the lowest window index supplies the translation.
- R10: The extension registers are stored and read back, but have no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte offset into the register space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr_in | input | 44 | Processor-side address to translate |
| ob_hit | output | 1 | An outbound window contains ob_addr_in |
| ob_addr_out | output | 44 | Translated PCI address |
| ib_addr_in | input | 44 | PCI-side address to translate |
| ib_hit | output | 1 | An inbound window contains ib_addr_in |
| ib_addr_out | output | 44 | Translated local address |

## Verification
The bench builds the block with its default parameters: four outbound windows, three inbound windows and a 10-bit register offset. This configuration is small enough to write and then read back every one of the 1024 offsets, so the bench confirms the whole decode map, including aliasing and unmapped holes.

Each window is then swept through size codes 0 to 12, plus an oversized code. Every sweep probes both edges of the range and disables the window again. Randomized rounds stack all windows over a few shared pages, which brings priority, disabled windows and extension registers within reach together.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

    localparam int ADDR_W    = 44;
    localparam int PAGE_W    = 12;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 10;
    localparam int GRP_LSB   = 5;
    localparam int GRP_W     = REG_AW - GRP_LSB;
    localparam int OB_N      = 4;
    localparam int IB_N      = 3;
    localparam int IDX_W     = 2;
    localparam int SIZE_W    = 6;
    localparam int EN_BIT    = 31;
    localparam int SHAMT_W   = SIZE_W + 1;

    localparam logic [GRP_W-1:0] OB_GRP_LO = GRP_W'(5'd1);
    localparam logic [GRP_W-1:0] OB_GRP_HI = GRP_W'(OB_N);
    localparam logic [GRP_W-1:0] IB_GRP_LO = GRP_W'(5'd13);
    localparam logic [GRP_W-1:0] IB_GRP_HI = GRP_W'(5'd15);
    localparam logic [GRP_W-1:0] TMR_GRP   = GRP_W'(5'd17);

    // Full architectural register set of one window.
    typedef struct packed {
        logic [DATA_W-1:0] tgt;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] attr;
    } win_t;

    // Subset that the lookup datapath consumes.
    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] code;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] tgt;
    } xwin_t;

    typedef enum logic [1:0] {SP_NONE, SP_OB, SP_IB, SP_TMR} space_e;
    typedef enum logic [2:0] {FL_TGT, FL_EXT, FL_BASE, FL_ATTR, FL_NONE} field_e;

    typedef struct packed {
        space_e           space;
        logic [IDX_W-1:0] idx;
        field_e           field;
    } dec_t;

    function automatic dec_t decode(input logic [REG_AW-1:0] off);
        dec_t d;
        logic [GRP_W-1:0]   grp;
        logic [GRP_LSB-1:0] lo;
        grp     = off[REG_AW-1:GRP_LSB];
        lo      = off[GRP_LSB-1:0];
        d.space = SP_NONE;
        d.idx   = '0;
        d.field = FL_NONE;
        if (grp >= OB_GRP_LO && grp <= OB_GRP_HI) begin
            d.space = SP_OB;
            d.idx   = IDX_W'(grp - OB_GRP_LO);
            case (lo)
                5'h00:   d.field = FL_TGT;
                5'h04:   d.field = FL_EXT;
                5'h08:   d.field = FL_BASE;
                5'h10:   d.field = FL_ATTR;
                default: d.field = FL_NONE;
            endcase
        end else if (grp >= IB_GRP_LO && grp <= IB_GRP_HI) begin
            d.space = SP_IB;
            d.idx   = IDX_W'(grp[IDX_W-1:0] - IDX_W'(1));
            case (lo)
                5'h00:   d.field = FL_TGT;
                5'h08:   d.field = FL_BASE;
                5'h0C:   d.field = FL_EXT;
                5'h10:   d.field = FL_ATTR;
                default: d.field = FL_NONE;
            endcase
        end else if (grp == TMR_GRP) begin
            d.space = SP_TMR;
        end
        if ((d.space == SP_OB || d.space == SP_IB) && d.field == FL_NONE)
            d.space = SP_NONE;
        return d;
    endfunction

    function automatic win_t put_field(input win_t w, input field_e f,
                                       input logic [DATA_W-1:0] v);
        win_t r;
        r = w;
        case (f)
            FL_TGT:  r.tgt  = v;
            FL_EXT:  r.ext  = v;
            FL_BASE: r.base = v;
            FL_ATTR: r.attr = v;
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_field(input win_t w, input field_e f);
        case (f)
            FL_TGT:  return w.tgt;
            FL_EXT:  return w.ext;
            FL_BASE: return w.base;
            FL_ATTR: return w.attr;
            default: return '0;
        endcase
    endfunction

    function automatic xwin_t to_xwin(input win_t w);
        xwin_t x;
        x.en   = w.attr[EN_BIT];
        x.code = w.attr[SIZE_W-1:0];
        x.base = w.base;
        x.tgt  = w.tgt;
        return x;
    endfunction

    function automatic logic [ADDR_W-1:0] page_to_addr(input logic [DATA_W-1:0] pg);
        return {pg, {PAGE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
    import pciwin_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [REG_AW-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output xwin_t [OB_N-1:0]        ob_x,
    output xwin_t [IB_N-1:0]        ib_x
);

    dec_t              dec;
    win_t [OB_N-1:0]   ob_q;
    win_t [IB_N-1:0]   ib_q;
    logic [DATA_W-1:0] tmr_q;

    assign dec = decode(addr);

    for (genvar g = 0; g < OB_N; g++) begin : g_ob
        win_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr && dec.space == SP_OB && dec.idx == IDX_W'(g))
                slot_q <= put_field(slot_q, dec.field, wdata);
        end
        assign ob_q[g] = slot_q;
        assign ob_x[g] = to_xwin(slot_q);
    end

    for (genvar g = 0; g < IB_N; g++) begin : g_ib
        win_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr && dec.space == SP_IB && dec.idx == IDX_W'(g))
                slot_q <= put_field(slot_q, dec.field, wdata);
        end
        assign ib_q[g] = slot_q;
        assign ib_x[g] = to_xwin(slot_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else if (wr && dec.space == SP_TMR)
            tmr_q <= wdata;
    end

    always_comb begin
        rdata = '0;
        case (dec.space)
            SP_OB: begin
                for (int i = 0; i < OB_N; i++)
                    if (dec.idx == IDX_W'(i)) rdata = get_field(ob_q[i], dec.field);
            end
            SP_IB: begin
                for (int i = 0; i < IB_N; i++)
                    if (dec.idx == IDX_W'(i)) rdata = get_field(ib_q[i], dec.field);
            end
            SP_TMR:  rdata = tmr_q;
            default: rdata = '0;
        endcase
    end

    // R1: reset clears the whole register file
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (tmr_q == '0 && ob_q == '0 && ib_q == '0));

    // R4: timer captures written data
    p_timer_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.space == SP_TMR) |=> tmr_q == $past(wdata));

    // R5: unmapped writes leave every register untouched
    p_unmapped_write_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.space == SP_NONE) |=> ($stable(ob_q) && $stable(ib_q) && $stable(tmr_q)));

    // R5: unmapped reads return zero
    p_unmapped_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (dec.space == SP_NONE) |-> rdata == '0);

endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate
    import pciwin_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  xwin_t [N-1:0]       wins,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic                hit,
    output logic [ADDR_W-1:0]   addr_out
);

    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]             match;
    logic [N-1:0][ADDR_W-1:0] tr;
    logic [SEL_W-1:0]         sel;

    for (genvar g = 0; g < N; g++) begin : g_win
        logic [ADDR_W-1:0]  base_b;
        logic [ADDR_W-1:0]  off;
        logic [SHAMT_W-1:0] shamt;
        logic               above;
        assign base_b   = page_to_addr(wins[g].base);
        assign off      = addr_in - base_b;
        assign above    = addr_in >= base_b;
        assign shamt    = SHAMT_W'(wins[g].code) + SHAMT_W'(1);
        assign match[g] = wins[g].en && above && ((off >> shamt) == '0);
        assign tr[g]    = page_to_addr(wins[g].tgt) + off;

        // R6 / R7: a selected window is enabled and starts at or below the address
        p_sel_valid_r6: assert property (@(posedge clk) disable iff (rst)
            (hit && sel == SEL_W'(g)) |-> (wins[g].en && addr_in >= base_b));

        // R9: no lower-indexed match may lose to a higher one
        p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
            match[g] |-> (hit && sel <= SEL_W'(g)));
    end

    always_comb begin
        hit      = 1'b0;
        sel      = '0;
        addr_out = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                sel      = SEL_W'(i);
                addr_out = tr[i];
            end
        end
    end

    // R8: a miss drives a zero address
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !hit |-> addr_out == '0);

endmodule

// File: rtl/pciwin_unit.sv
module pciwin_unit
    import pciwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [ADDR_W-1:0]   ob_addr_in,
    output logic                ob_hit,
    output logic [ADDR_W-1:0]   ob_addr_out,
    input  logic [ADDR_W-1:0]   ib_addr_in,
    output logic                ib_hit,
    output logic [ADDR_W-1:0]   ib_addr_out
);

    xwin_t [OB_N-1:0] ob_x;
    xwin_t [IB_N-1:0] ib_x;

    pciwin_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ob_x  (ob_x),
        .ib_x  (ib_x)
    );

    pciwin_xlate #(.N(OB_N)) u_ob_xlate (
        .clk      (clk),
        .rst      (rst),
        .wins     (ob_x),
        .addr_in  (ob_addr_in),
        .hit      (ob_hit),
        .addr_out (ob_addr_out)
    );

    pciwin_xlate #(.N(IB_N)) u_ib_xlate (
        .clk      (clk),
        .rst      (rst),
        .wins     (ib_x),
        .addr_in  (ib_addr_in),
        .hit      (ib_hit),
        .addr_out (ib_addr_out)
    );

endmodule

// File: tb/pciwin_unit_bench.sv
module pciwin_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [43:0] ob_addr_in, ob_addr_out, ib_addr_in, ib_addr_out;
    logic        ob_hit, ib_hit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] m_t [2][4];
    logic [31:0] m_e [2][4];
    logic [31:0] m_b [2][4];
    logic [31:0] m_a [2][4];
    logic [31:0] shadow [29];
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    pciwin_unit u_pciwin_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ob_addr_in(ob_addr_in), .ob_hit(ob_hit), .ob_addr_out(ob_addr_out),
        .ib_addr_in(ib_addr_in), .ib_hit(ib_hit), .ib_addr_out(ib_addr_out)
    );

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Register key: 0..15 outbound (w*4 + {tgt,ext,base,attr}), 16..27 inbound, 28 timer, -1 none
    function automatic int key_of(int o);
        int g, lo, w;
        g  = o >> 5;
        lo = o & 31;
        if (g >= 1 && g <= 4) begin
            w = g - 1;
            case (lo)
                0: return w * 4;
                4: return w * 4 + 1;
                8: return w * 4 + 2;
                16: return w * 4 + 3;
                default: return -1;
            endcase
        end
        if (g >= 13 && g <= 15) begin
            w = g - 13;
            case (lo)
                0: return 16 + w * 4;
                12: return 16 + w * 4 + 1;
                8: return 16 + w * 4 + 2;
                16: return 16 + w * 4 + 3;
                default: return -1;
            endcase
        end
        if (g == 17) return 28;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 10'(off); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int off, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = 10'(off);
        #1;
        chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    function automatic int grp_base(int s, int i);
        return (s == 0) ? 32 * (i + 1) : 32'h1A0 + 32 * i;
    endfunction

    task automatic set_attr(input int s, input int i, input logic [31:0] a);
        wr(grp_base(s, i) + 16, a);
        m_a[s][i] = a;
    endtask

    task automatic set_win(input int s, input int i, input logic [31:0] t, input logic [31:0] e,
                           input logic [31:0] b, input logic [31:0] a);
        wr(grp_base(s, i), t);
        wr(grp_base(s, i) + ((s == 0) ? 4 : 12), e);
        wr(grp_base(s, i) + 8, b);
        set_attr(s, i, a);
        m_t[s][i] = t; m_e[s][i] = e; m_b[s][i] = b;
    endtask

    function automatic void model(input int s, input logic [43:0] a, output bit h, output logic [43:0] o);
        int n, c;
        logic [63:0] bb, aa, off;
        bit inr;
        n = (s == 1) ? 3 : 4;
        h = 0; o = '0;
        for (int i = n - 1; i >= 0; i--) begin
            if (m_a[s][i][31]) begin
                bb = {20'd0, m_b[s][i], 12'd0};
                aa = {20'd0, a};
                c  = int'(m_a[s][i][5:0]);
                if (aa >= bb) begin
                    off = aa - bb;
                    inr = (c >= 62) ? 1'b1 : (off < (64'd2 << c));
                    if (inr) begin
                        h = 1;
                        o = 44'({20'd0, m_t[s][i], 12'd0} + off);
                    end
                end
            end
        end
    endfunction

    task automatic probe(input int s, input logic [43:0] a, input string req);
        bit eh;
        logic [43:0] eo;
        bit ah;
        logic [43:0] ao;
        @(negedge clk);
        if (s == 0) ob_addr_in = a; else ib_addr_in = a;
        #1;
        ah = (s == 0) ? ob_hit : ib_hit;
        ao = (s == 0) ? ob_addr_out : ib_addr_out;
        model(s, a, eh, eo);
        chk(ah == eh, {req, " hit"}, 64'(ah), 64'(eh));
        chk(ao == eo, {req, " addr"}, 64'(ao), 64'(eo));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [43:0] bb, sz, a;
        int k;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin
                m_t[s][i] = '0; m_e[s][i] = '0; m_b[s][i] = '0; m_a[s][i] = '0;
            end
        for (int i = 0; i < 29; i++) shadow[i] = '0;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ob_addr_in = '0; ib_addr_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk(32'h030, 32'h0, "R1 ob attr");
        rd_chk(32'h1B0, 32'h0, "R1 ib attr");
        rd_chk(32'h220, 32'h0, "R1 timer");
        probe(0, 44'h0, "R1 ob");
        probe(1, 44'h0, "R1 ib");

        // R2 R3 R4 R5: write every offset, then read back every offset
        for (int o = 0; o < 1024; o++) begin
            v = 32'hA500_0000 ^ (32'(o) * 32'h0001_9E37) ^ (32'(o) << 21);
            wr(o, v);
            k = key_of(o);
            if (k >= 0) shadow[k] = v;
        end
        for (int o = 0; o < 1024; o++) begin
            k = key_of(o);
            rd_chk(o, (k >= 0) ? shadow[k] : 32'h0,
                   (k < 0) ? "R5 unmapped" : (k == 28) ? "R4 timer" : (k < 16) ? "R2 outbound" : "R3 inbound");
        end

        // Bring model in line with the swept register contents, then clear windows
        for (int i = 0; i < 4; i++) begin
            m_t[0][i] = shadow[i*4]; m_e[0][i] = shadow[i*4+1];
            m_b[0][i] = shadow[i*4+2]; m_a[0][i] = shadow[i*4+3];
        end
        for (int i = 0; i < 3; i++) begin
            m_t[1][i] = shadow[16+i*4]; m_e[1][i] = shadow[16+i*4+1];
            m_b[1][i] = shadow[16+i*4+2]; m_a[1][i] = shadow[16+i*4+3];
        end
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < ((s == 0) ? 4 : 3); i++) set_attr(s, i, 32'h0);

        // R7 R8 R6: per-window size sweep with range edges
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < ((s == 0) ? 4 : 3); i++) begin
                for (int c = 0; c < 14; c++) begin
                    int code;
                    code = (c == 13) ? 50 : c;
                    set_win(s, i, 32'h000A_B000 + 32'(c), 32'hDEAD_0000 + 32'(c),
                            32'h0001_2340 + 32'(i << 4), 32'h8000_0000 | 32'(code));
                    bb = {m_b[s][i], 12'h0};
                    sz = (code >= 43) ? 44'h0 : (44'd2 << code);
                    probe(s, bb - 44'd1, "R7 below");
                    probe(s, bb, "R7 base R8");
                    if (code < 43) begin
                        probe(s, bb + sz - 44'd1, "R7 last R8");
                        probe(s, bb + sz, "R7 past end");
                    end else begin
                        probe(s, 44'hFFF_FFFF_FFFF, "R7 oversize R8");
                    end
                    set_attr(s, i, 32'h0000_0000 | 32'(code));
                    probe(s, bb, "R6 disabled");
                end
                set_attr(s, i, 32'h0);
            end
        end

        // R8: modular wrap of the translated address
        set_win(0, 0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h8000_0014);
        probe(0, 44'h0_1005, "R8 wrap");
        set_attr(0, 0, 32'h0);

        // R6 R9 R10: overlapping randomized windows
        for (int r = 0; r < 40; r++) begin
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < ((s == 0) ? 4 : 3); i++)
                    set_win(s, i, nxt(), nxt(), {28'd0, 4'(nxt())},
                            {(nxt() % 5) != 0, 25'd0, 6'(nxt() % 17)});
            for (int p = 0; p < 12; p++) begin
                a = {27'd0, 5'(nxt() % 21), 12'(nxt())};
                probe(0, a, "R9 R10 R6 ob");
                probe(1, a, "R9 R10 R6 ib");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule